// File: doc/BRIEF.md
# Paged Write Buffer Controller

This block models the write front end of a byte-wide paged nonvolatile memory, sampled entirely on a system clock. The host drives an address, a data byte and three active-low strobes (chip select, write strobe, read enable). A write cycle is recognised when chip select and write strobe are both low while read enable is high. The byte is placed in a page buffer, and the buffer marks that offset as loaded. The first byte of an operation fixes the page. Later bytes for the same page may arrive in any order and may overwrite each other.

When no accepted byte has arrived for a programmable number of cycles, the load window closes. The block then raises busy for a fixed, programmable number of cycles. During that time it copies only the loaded offsets of the buffered page into the backing array. At the end it clears the loaded flags. A plain read port returns the array contents whenever chip select and read enable are low and the write strobe is high.

Top module: `pwb_ctrl`

## Requirements
- R1: After reset, busy is low and every array byte reads as 8'h00.
- R2: With ce_n=0, oe_n=0 and we_n=1, dout equals the array byte at addr. Otherwise dout is 8'h00.
- R3: The address is taken in the first cycle in which ce_n and we_n are both seen low. The data is taken in the first later cycle in which either of them is seen high.
- R4: A write cycle starts only if oe_n is high and busy is low in its starting cycle. Otherwise the strobe pair has no effect.
- R5: Bytes of one page may be loaded in any order. Loading an offset again before the window closes replaces its buffered value.
- R6: The page, meaning the address bits above the low OFF_W offset bits, is fixed by the first accepted byte. A byte for any other page is dropped. A dropped byte leaves the buffer unchanged and does not restart the window.
- R7: Programming begins LOAD_CYC cycles after the data cycle of the last accepted byte. Each accepted byte restarts this count.
- R8: Busy stays high for exactly PROG_CYC consecutive cycles per programming phase.
- R9: Programming writes the buffered value to every loaded offset of the page. All other array bytes keep their values.
- R10: Strobes seen while busy are ignored. The loaded flags are clear after programming, so the next operation writes only its own offsets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | PG_W+OFF_W | Byte address; low OFF_W bits are the offset in the page |
| din | input | 8 | Write data |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read enable, active low; a low level blocks write starts |
| dout | output | 8 | Read data, 8'h00 when not reading |
| busy | output | 1 | High during the internal programming phase |

## Verification
The bench uses a small configuration with 8-byte pages and 4 pages. After every operation it reads back the whole array and compares it against a model that the bench updates from the requirements.

The write patterns are:
- a single byte, which separates "flagged only" from "whole page";
- a full page loaded in descending order with one offset rewritten, which exposes ordering and overwrite faults;
- a foreign-page byte within a load, which shows both buffer corruption and wrongful window restarts through the measured delay to busy;
- blocked starts, with read enable low or chip select high;
- strobes during busy;
- a split strobe sequence where the address and data change between edges, which separates the capture points;
- two bytes separated by less than one window, which checks that the count restarts.

// File: rtl/pwb_pkg.sv
// Shared types for the paged write buffer controller.
package pwb_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } phase_t;
endpackage

// File: rtl/pwb_strobe.sv
// Strobe decoder.
// Turns the sampled active-low strobes into one commit pulse per write cycle.
// The address is captured when the chip-select/write pair first becomes
// active; the commit (data) cycle is the first cycle in which the pair is
// released.
// Assumes: strobes are already synchronous to clk; oe_n is checked only in
// the starting cycle.
module pwb_strobe #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        din_i,
    output logic              commit_o,
    output logic [ADDR_W-1:0] c_addr_o,
    output logic [7:0]        c_data_o
);
    logic              act;
    logic              act_q;
    logic              pend_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rise;
    logic              fall;

    // Decode the active write pair and its edges.
    always_comb begin
        act  = ~ce_n & ~we_n;
        rise = act & ~act_q;
        fall = ~act & act_q;
    end

    // Track the pair, arm a pending write and latch the address on its start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            pend_q <= 1'b0;
            addr_q <= '0;
        end else begin
            act_q <= act;
            if (rise && oe_n && !busy_i) begin
                pend_q <= 1'b1;
                addr_q <= addr_i;
            end else if (fall) begin
                pend_q <= 1'b0;
            end
        end
    end

    // Emit the commit on the first release cycle, using the data present then.
    always_comb begin
        commit_o = fall & pend_q & ~busy_i;
        c_addr_o = addr_q;
        c_data_o = din_i;
    end

    // R4
    oe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !act_q && !oe_n) |=> !pend_q);
endmodule

// File: rtl/pwb_page_buf.sv
// Page buffer.
// Holds one page of bytes, a loaded flag per offset and the page tag.
// The first accepted byte fixes the tag; bytes for other pages are dropped.
// Assumes: commit_i never coincides with clear_i (commits are blocked while
// busy).
module pwb_page_buf #(
    parameter int OFF_W = 7,
    parameter int PG_W  = 3,
    localparam int ADDR_W     = OFF_W + PG_W,
    localparam int PAGE_BYTES = 1 << OFF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit_i,
    input  logic [ADDR_W-1:0]     c_addr_i,
    input  logic [7:0]            c_data_i,
    input  logic                  clear_i,
    input  logic [OFF_W-1:0]      rd_idx_i,
    output logic [7:0]            rd_data_o,
    output logic [PAGE_BYTES-1:0] valid_o,
    output logic [PG_W-1:0]       tag_o,
    output logic                  accept_o
);
    logic [7:0]            buf_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid_q;
    logic [PG_W-1:0]       tag_q;
    logic                  empty;
    logic                  match;
    logic [OFF_W-1:0]      off;

    // Decide whether the committed byte belongs to this page operation.
    always_comb begin
        empty    = ~|valid_q;
        match    = c_addr_i[ADDR_W-1:OFF_W] == tag_q;
        off      = c_addr_i[OFF_W-1:0];
        accept_o = commit_i & (empty | match);
    end

    // Store accepted bytes, set their flags and fix the tag on the first one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            tag_q   <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) buf_q[i] <= 8'h00;
        end else if (clear_i) begin
            valid_q <= '0;
        end else if (accept_o) begin
            buf_q[off]   <= c_data_i;
            valid_q[off] <= 1'b1;
            if (empty) tag_q <= c_addr_i[ADDR_W-1:OFF_W];
        end
    end

    // Expose the contents to the copier.
    always_comb begin
        rd_data_o = buf_q[rd_idx_i];
        valid_o   = valid_q;
        tag_o     = tag_q;
    end

    // R6
    page_tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|valid_q && !clear_i) |=> tag_q == $past(tag_q));
    // R10
    flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> valid_q == '0);
endmodule

// File: rtl/pwb_timer.sv
// Phase sequencer.
// Runs the load window (restarted by every accepted byte) and the fixed
// programming phase. During programming it scans offsets 0..PAGE_BYTES-1,
// one per cycle, and pulses clear on the last busy cycle.
// Assumes: PROG_CYC >= PAGE_BYTES, LOAD_CYC >= 1.
module pwb_timer #(
    parameter int OFF_W    = 7,
    parameter int LOAD_CYC = 15000,
    parameter int PROG_CYC = 1000000,
    localparam int PAGE_BYTES = 1 << OFF_W,
    localparam int LW   = $clog2(LOAD_CYC + 1),
    localparam int PMAX = (PROG_CYC > PAGE_BYTES) ? PROG_CYC : PAGE_BYTES,
    localparam int PW   = $clog2(PMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    output logic             busy_o,
    output logic             clear_o,
    output logic             scan_o,
    output logic [OFF_W-1:0] idx_o
);
    import pwb_pkg::*;

    phase_t        state_q;
    logic [LW-1:0] wcnt_q;
    logic [PW-1:0] pcnt_q;
    logic          prog_last;

    // Flag the final programming cycle.
    always_comb prog_last = (state_q == PH_PROG) && (pcnt_q == PW'(PROG_CYC - 1));

    // Advance the phase and its counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            wcnt_q  <= '0;
            pcnt_q  <= '0;
        end else begin
            case (state_q)
                PH_IDLE: begin
                    if (accept_i) begin
                        state_q <= PH_LOAD;
                        wcnt_q  <= '0;
                    end
                end
                PH_LOAD: begin
                    if (accept_i) begin
                        wcnt_q <= '0;
                    end else if (wcnt_q == LW'(LOAD_CYC - 1)) begin
                        state_q <= PH_PROG;
                        pcnt_q  <= '0;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                PH_PROG: begin
                    if (prog_last) state_q <= PH_IDLE;
                    else           pcnt_q  <= pcnt_q + 1'b1;
                end
                default: state_q <= PH_IDLE;
            endcase
        end
    end

    // Drive the busy flag and the copier scan.
    always_comb begin
        busy_o  = state_q == PH_PROG;
        clear_o = prog_last;
        scan_o  = (state_q == PH_PROG) && (pcnt_q < PW'(PAGE_BYTES));
        idx_o   = pcnt_q[OFF_W-1:0];
    end

    // R8
    prog_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_PROG && pcnt_q != PW'(PROG_CYC - 1)) |=> state_q == PH_PROG);
    // R7
    window_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> (state_q == PH_LOAD && wcnt_q == '0));
endmodule

// File: rtl/pwb_ctrl.sv
// Paged write buffer controller (top).
// Connects the strobe decoder, the page buffer and the phase sequencer to a
// backing byte array with a combinational read port. During programming the
// loaded offsets of the buffered page are copied into the array.
// Assumes: synchronous host strobes; PROG_CYC >= 2**OFF_W.
module pwb_ctrl #(
    parameter int OFF_W    = 7,
    parameter int PG_W     = 3,
    parameter int LOAD_CYC = 15000,
    parameter int PROG_CYC = 1000000,
    localparam int ADDR_W     = OFF_W + PG_W,
    localparam int DEPTH      = 1 << ADDR_W,
    localparam int PAGE_BYTES = 1 << OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    output logic [7:0]        dout,
    output logic              busy
);
    logic                  commit;
    logic [ADDR_W-1:0]     c_addr;
    logic [7:0]            c_data;
    logic                  accept;
    logic                  clr;
    logic                  scan;
    logic [OFF_W-1:0]      idx;
    logic [7:0]            bdata;
    logic [PAGE_BYTES-1:0] valid;
    logic [PG_W-1:0]       tag;
    logic [7:0]            mem [DEPTH];
    logic                  rd_en;
    logic                  copy_en;

    pwb_strobe #(.ADDR_W(ADDR_W)) strobe_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .busy_i(busy), .addr_i(addr), .din_i(din),
        .commit_o(commit), .c_addr_o(c_addr), .c_data_o(c_data)
    );

    pwb_page_buf #(.OFF_W(OFF_W), .PG_W(PG_W)) buf_i (
        .clk(clk), .rst_n(rst_n), .commit_i(commit), .c_addr_i(c_addr),
        .c_data_i(c_data), .clear_i(clr), .rd_idx_i(idx), .rd_data_o(bdata),
        .valid_o(valid), .tag_o(tag), .accept_o(accept)
    );

    pwb_timer #(.OFF_W(OFF_W), .LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC)) tmr_i (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .busy_o(busy),
        .clear_o(clr), .scan_o(scan), .idx_o(idx)
    );

    // Copy only flagged offsets while scanning.
    always_comb copy_en = scan & valid[idx];

    // Hold the backing array and apply the copier writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (copy_en) begin
            mem[{tag, idx}] <= bdata;
        end
    end

    // Serve reads when selected with read enable and no write strobe.
    always_comb begin
        rd_en = ~ce_n & ~oe_n & we_n;
        dout  = rd_en ? mem[addr] : 8'h00;
    end

    // R10
    busy_noload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !clr) |=> $stable(valid));
endmodule

// File: tb/pwb_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwb_ctrl_tb_top;
    localparam int OFF_W = 3;
    localparam int PG_W  = 2;
    localparam int LCYC  = 20;
    localparam int PCYC  = 12;
    localparam int AW    = OFF_W + PG_W;
    localparam int NB    = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = 8'h00;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [7:0]    dout;
    logic          busy;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic [7:0] exp_mem [NB];

    pwb_ctrl #(.OFF_W(OFF_W), .PG_W(PG_W), .LOAD_CYC(LCYC), .PROG_CYC(PCYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n),
        .we_n(we_n), .oe_n(oe_n), .dout(dout), .busy(busy)
    );

    always #2.5 clk = ~clk;

    function automatic logic [AW-1:0] pa(input int p, input int o);
        return AW'(p * (1 << OFF_W) + o);
    endfunction

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Plain write cycle; starts and ends just after a falling clock edge.
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic oe = 1'b1);
        addr = a; din = d; oe_n = oe; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        oe_n = 1'b1;
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < NB; i++) begin
            addr = AW'(i); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
            #1;
            check(req, dout, exp_mem[i]);
        end
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic measure(output int n, output int m);
        n = 0;
        while (!busy) begin @(negedge clk); n++; end
        m = 0;
        while (busy) begin @(negedge clk); m++; end
    endtask

    task automatic quiet(input string req, input int cyc);
        int seen = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (busy) seen++;
        end
        check(req, seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, m;
        for (int i = 0; i < NB; i++) exp_mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R2 idle output
        check("R1 busy after reset", busy, 0);
        addr = pa(1, 3);
        #1 check("R2 dout when not reading", dout, 0);
        @(negedge clk);
        read_all("R1 reset contents");

        // R7 R8 R9 single byte
        wr(pa(1, 3), 8'hA5);
        measure(n, m);
        check("R7 window length", n, LCYC);
        check("R8 busy length", m, PCYC);
        exp_mem[pa(1, 3)] = 8'hA5;
        read_all("R9 single byte");

        // R5 full page, descending order, one overwrite
        for (int o = (1 << OFF_W) - 1; o >= 0; o--) wr(pa(2, o), 8'h30 + 8'(o));
        wr(pa(2, 4), 8'hEE);
        measure(n, m);
        check("R7 window after page", n, LCYC);
        check("R8 busy after page", m, PCYC);
        for (int o = 0; o < (1 << OFF_W); o++) exp_mem[pa(2, o)] = 8'h30 + 8'(o);
        exp_mem[pa(2, 4)] = 8'hEE;
        read_all("R5 page order and overwrite");

        // R6 foreign page dropped, no restart; R10 flags cleared after page 2
        wr(pa(3, 1), 8'h11);
        wr(pa(0, 2), 8'h22);
        measure(n, m);
        check("R6 no restart on foreign byte", n, LCYC - 2);
        exp_mem[pa(3, 1)] = 8'h11;
        read_all("R6 R10 foreign byte and cleared flags");

        // R4 read enable low blocks start; chip select high blocks start
        wr(pa(0, 5), 8'h55, 1'b0);
        quiet("R4 oe low no program", LCYC + PCYC + 4);
        addr = pa(0, 6); din = 8'h66; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1; @(negedge clk);
        quiet("R4 ce high no program", LCYC + PCYC + 4);
        read_all("R4 blocked writes");

        // R10 strobes during busy ignored
        wr(pa(1, 0), 8'h77);
        while (!busy) @(negedge clk);
        wr(pa(1, 1), 8'h88);
        while (busy) @(negedge clk);
        quiet("R10 no second program", LCYC + 5);
        exp_mem[pa(1, 0)] = 8'h77;
        read_all("R10 write during busy");

        // R3 address at later falling edge, data at first rising edge
        addr = pa(1, 5); din = 8'h00; oe_n = 1'b1; ce_n = 1'b0;
        @(negedge clk);
        addr = pa(1, 6); din = 8'h5C; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        din = 8'hC5; ce_n = 1'b1;
        @(negedge clk);
        measure(n, m);
        exp_mem[pa(1, 6)] = 8'h5C;
        read_all("R3 capture points");

        // R7 restart by a byte inside the window
        wr(pa(0, 0), 8'h01);
        repeat (LCYC - 5) @(negedge clk);
        check("R7 still loading", busy, 0);
        wr(pa(0, 7), 8'h07);
        measure(n, m);
        check("R7 restarted window", n, LCYC);
        exp_mem[pa(0, 0)] = 8'h01;
        exp_mem[pa(0, 7)] = 8'h07;
        read_all("R7 R9 two bytes one program");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule